// File: doc/BRIEF.md
# Memory-Mapped Dual Serial Port Decoder

This block sits on the data side of a 16-bit processor, between the core's word-addressed load/store requests and a synchronous RAM. It checks each request against a fixed map of permitted addresses and forwards legal ones to the RAM. It rejects the rest with a one-cycle fault pulse.

Two character channels are mapped into the address space. Each has a data word at an even address and a status word at the next odd address. A write to a data word hands its low byte to that channel's transmitter. A read of a data word returns the byte most recently received.

Two status flags report the channel state: transmitter ready (bit 0) and receive byte waiting (bit 1). Port traffic and channel handshakes set and clear these flags as side effects. The serial line itself and the RAM array lie outside the block. Only addresses below 0xE000 can ever pass the map, which fits a RAM of 0xE000 words.

Top module: `serial_port_bus_decoder`

## Requirements
- R1: A request is permitted when its address is below 0x2800, or lies from 0x4000 up to and including 0x6003. For any other address, `access_fault` is high in exactly the cycle the request is presented, and only then.
- R2: A faulted request reaches neither the RAM nor the channels. `mem_en` stays low, no response is produced, and no status flag, transmit byte or receive byte changes.
- R3: A permitted request drives `mem_en` in the same cycle, with `mem_we`, `mem_addr` and `mem_wdata` copied from the request. This includes writes to data and status words.
- R4: A permitted read gives `rsp_valid` high for one cycle on the cycle after the request, with the read word on `rsp_rdata`. For ordinary addresses that word is the RAM's output.
- R5: A read of data word 0x6000 (channel 0) or 0x6002 (channel 1) returns the held receive byte in bits 7:0, with bits 15:8 zero. It clears bit 1 of that channel's status.
- R6: A write to a channel's data word loads the low 8 bits of the write data into that channel's `tx_byte` lane and raises its `tx_valid` from the next cycle. It also clears status bit 0.
- R7: A read of the status word (data address plus 1: 0x6001 or 0x6003) returns bit 0 = transmitter ready and bit 1 = receive byte waiting, with all other bits zero. After reset the word reads 0x0001.
- R8: While `tx_valid` of a channel is high, a `tx_accept` pulse on that channel drops `tx_valid` on the next cycle and sets status bit 0 again.
- R9: An `rx_valid` pulse stores `rx_byte` for the channel and sets status bit 1. If it arrives in the same cycle as a read of that channel's data word, the read returns the previously held byte, while the new byte is kept and bit 1 stays set.
- R10: The two channels are independent. Traffic on one never changes the other's flags or bytes.
- R11: A write to a status word updates only the RAM. The channel's status flags and transmitter are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 16 | Read data |
| access_fault | output | 1 | Request rejected by the address map |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after `mem_en` |
| tx_valid | output | 2 | Per channel: transmit byte pending |
| tx_byte | output | 16 | Transmit bytes, channel 1 in bits 15:8 |
| tx_accept | input | 2 | Per channel: transmitter took the byte |
| rx_valid | input | 2 | Per channel: new received byte |
| rx_byte | input | 16 | Received bytes, channel 1 in bits 15:8 |

## Verification
The fault pulse and the RAM strobes are combinational, so they are sampled one time step after the request is driven, before the clock edge that takes it. Read data, `tx_valid`, `tx_byte` and every status flag change are registered. They are sampled at the falling edge that follows the capturing rising edge. Each status effect is confirmed by a later read of the status word through the bus, which returns the value held before that read's own edge. Inputs are always driven at falling edges, so nothing depends on process order at the rising edge.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ACC_MEM  = 2'd0,
    ACC_DATA = 2'd1,
    ACC_STAT = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sp_addr_decode.sv
module sp_addr_decode
  import sp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int N_CH      = 2,
  parameter int CH_W      = 1,
  parameter logic [ADDR_W-1:0] LOW_END   = 16'h2800,
  parameter logic [ADDR_W-1:0] WIN_LO    = 16'h4000,
  parameter logic [ADDR_W-1:0] WIN_HI    = 16'h6003,
  parameter logic [ADDR_W-1:0] PORT_BASE = 16'h6000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              permitted,
  output acc_kind_e         kind,
  output logic [CH_W-1:0]   ch
);
  localparam logic [ADDR_W-1:0] PORT_END = PORT_BASE + ADDR_W'(2 * N_CH);

  logic [ADDR_W-1:0] offset;
  logic              in_ports;

  always_comb begin
    permitted = (addr < LOW_END) || ((addr >= WIN_LO) && (addr <= WIN_HI));
    offset    = addr - PORT_BASE;
    in_ports  = (addr >= PORT_BASE) && (addr < PORT_END);
    ch        = offset[CH_W:1];
    if (!in_ports)     kind = ACC_MEM;
    else if (addr[0])  kind = ACC_STAT;
    else               kind = ACC_DATA;
  end
endmodule

// File: rtl/sp_chan.sv
module sp_chan #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_port,
  input  logic              rd_port,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              tx_accept,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_hold,
  output logic              stat_ready,
  output logic              stat_full
);
  logic              tx_pend_q, tx_pend_d;
  logic [BYTE_W-1:0] tx_byte_q, tx_byte_d;
  logic              full_q, full_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              tx_en, rx_en;

  always_comb begin
    tx_pend_d = tx_pend_q;
    tx_byte_d = tx_byte_q;
    if (tx_accept && tx_pend_q) tx_pend_d = 1'b0;
    if (wr_port) begin
      tx_pend_d = 1'b1;
      tx_byte_d = wbyte;
    end
    tx_en = wr_port || tx_accept;
  end

  always_comb begin
    full_d = full_q;
    hold_d = hold_q;
    if (rd_port) full_d = 1'b0;
    if (rx_valid) begin
      full_d = 1'b1;
      hold_d = rx_byte;
    end
    rx_en = rd_port || rx_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend_q <= 1'b0;
      tx_byte_q <= '0;
    end else if (tx_en) begin
      tx_pend_q <= tx_pend_d;
      tx_byte_q <= tx_byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (rx_en) begin
      full_q <= full_d;
      hold_q <= hold_d;
    end
  end

  assign tx_valid   = tx_pend_q;
  assign tx_byte    = tx_byte_q;
  assign rx_hold    = hold_q;
  assign stat_ready = !tx_pend_q;
  assign stat_full  = full_q;

  // R6: a port write leaves a pending byte equal to the written low byte
  p_write_loads_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_port |=> (tx_valid && tx_byte == $past(wbyte)));

  // R8: acceptance without a fresh write frees the transmitter
  p_accept_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_accept && !wr_port) |=> stat_ready);

  // R9: an arriving byte is held and flagged
  p_rx_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (stat_full && rx_hold == $past(rx_byte)));

  // R5: a port read with no new arrival drains the flag
  p_read_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_port && !rx_valid) |=> !stat_full);
endmodule

// File: rtl/serial_port_bus_decoder.sv
module serial_port_bus_decoder
  import sp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int N_CH   = 2,
  parameter logic [ADDR_W-1:0] LOW_END   = 16'h2800,
  parameter logic [ADDR_W-1:0] WIN_LO    = 16'h4000,
  parameter logic [ADDR_W-1:0] WIN_HI    = 16'h6003,
  parameter logic [ADDR_W-1:0] PORT_BASE = 16'h6000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     access_fault,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic [N_CH-1:0]          tx_valid,
  output logic [N_CH*BYTE_W-1:0]   tx_byte,
  input  logic [N_CH-1:0]          tx_accept,
  input  logic [N_CH-1:0]          rx_valid,
  input  logic [N_CH*BYTE_W-1:0]   rx_byte
);
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic            permitted;
  acc_kind_e       kind;
  logic [CH_W-1:0] ch;

  sp_addr_decode #(
    .ADDR_W(ADDR_W), .N_CH(N_CH), .CH_W(CH_W),
    .LOW_END(LOW_END), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .PORT_BASE(PORT_BASE)
  ) i_decode (
    .addr(req_addr), .permitted(permitted), .kind(kind), .ch(ch)
  );

  logic go;
  assign go           = req_valid && permitted;
  assign access_fault = req_valid && !permitted;
  assign mem_en       = go;
  assign mem_we       = req_write;
  assign mem_addr     = req_addr;
  assign mem_wdata    = req_wdata;

  logic [BYTE_W-1:0] hold_a  [N_CH];
  logic [N_CH-1:0]   ready_v, full_v;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic sel;
    assign sel = go && (kind == ACC_DATA) && (ch == CH_W'(g));
    sp_chan #(.BYTE_W(BYTE_W)) i_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_port   (sel && req_write),
      .rd_port   (sel && !req_write),
      .wbyte     (req_wdata[BYTE_W-1:0]),
      .tx_accept (tx_accept[g]),
      .rx_valid  (rx_valid[g]),
      .rx_byte   (rx_byte[g*BYTE_W +: BYTE_W]),
      .tx_valid  (tx_valid[g]),
      .tx_byte   (tx_byte[g*BYTE_W +: BYTE_W]),
      .rx_hold   (hold_a[g]),
      .stat_ready(ready_v[g]),
      .stat_full (full_v[g])
    );
  end

  // response path: port words captured at the request edge, RAM word passed through
  logic              rd_go;
  logic [DATA_W-1:0] port_word_d, port_word_q;
  logic              rsp_valid_q, from_mem_q;
  logic              rsp_en;

  always_comb begin
    rd_go       = go && !req_write;
    port_word_d = '0;
    if (kind == ACC_DATA) port_word_d[BYTE_W-1:0] = hold_a[ch];
    else                  port_word_d[1:0]        = {full_v[ch], ready_v[ch]};
    rsp_en      = rd_go || rsp_valid_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid_q <= 1'b0;
      from_mem_q  <= 1'b1;
      port_word_q <= '0;
    end else if (rsp_en) begin
      rsp_valid_q <= rd_go;
      from_mem_q  <= (kind == ACC_MEM);
      port_word_q <= port_word_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = from_mem_q ? mem_rdata : port_word_q;

  // R2: a rejected request never reaches the RAM
  p_fault_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    access_fault |-> !mem_en);

  // R2: a rejected request yields no response
  p_fault_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    access_fault |=> !rsp_valid);

  // R4: each permitted read is answered on the next cycle
  p_read_answered_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !req_write && !access_fault) |=> rsp_valid);

  // R1: addresses of 0xE000 and above are always rejected
  p_top_range_faults_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_addr >= 16'hE000) |-> access_fault);
endmodule

// File: tb/test_serial_port_bus_decoder.sv
`timescale 1ns/100ps
module test_serial_port_bus_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_valid, access_fault, mem_en, mem_we;
  logic [15:0] rsp_rdata, mem_addr, mem_wdata;
  logic [15:0] mem_rdata;
  logic [1:0]  tx_valid, tx_accept, rx_valid;
  logic [15:0] tx_byte, rx_byte;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_port_bus_decoder i_serial_port_bus_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .access_fault(access_fault), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_accept(tx_accept), .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  // RAM stand-in: read word = address ^ 0x5A5A, one cycle late; writes recorded
  logic [15:0] last_wa, last_wd;
  int          wr_cnt = 0;
  always @(posedge clk) begin
    if (mem_en && !mem_we) mem_rdata <= mem_addr ^ 16'h5A5A;
    if (mem_en && mem_we) begin
      last_wa <= mem_addr;
      last_wd <= mem_wdata;
      wr_cnt  <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic        s_fault, s_men, s_rvalid;
  logic [15:0] s_rdata;

  task automatic cyc(input logic rv, input logic wr, input logic [15:0] a,
                     input logic [15:0] wd, input logic [1:0] rxv,
                     input logic [15:0] rxb, input logic [1:0] txa);
    @(negedge clk);
    req_valid = rv; req_write = wr; req_addr = a; req_wdata = wd;
    rx_valid = rxv; rx_byte = rxb; tx_accept = txa;
    #1;
    s_fault = access_fault;
    s_men   = mem_en;
    @(negedge clk);
    s_rvalid = rsp_valid;
    s_rdata  = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0; rx_valid = '0; tx_accept = '0;
  endtask

  task automatic rd(input logic [15:0] a);
    cyc(1'b1, 1'b0, a, 16'h0, 2'b00, 16'h0, 2'b00);
  endtask

  task automatic wrt(input logic [15:0] a, input logic [15:0] d);
    cyc(1'b1, 1'b1, a, d, 2'b00, 16'h0, 2'b00);
  endtask

  // {address, expected fault, expected read word}
  localparam logic [32:0] VEC [12] = '{
    {16'h0000, 1'b0, 16'h5A5A}, {16'h27FF, 1'b0, 16'h7DA5},
    {16'h2800, 1'b1, 16'h0000}, {16'h3FFF, 1'b1, 16'h0000},
    {16'h4000, 1'b0, 16'h1A5A}, {16'h5FFF, 1'b0, 16'h05A5},
    {16'h6001, 1'b0, 16'h0001}, {16'h6003, 1'b0, 16'h0001},
    {16'h6004, 1'b1, 16'h0000}, {16'hDFFF, 1'b1, 16'h0000},
    {16'hE000, 1'b1, 16'h0000}, {16'hFFFF, 1'b1, 16'h0000}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int wc;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    rx_valid = 0; rx_byte = 0; tx_accept = 0;
    repeat (3) @(negedge clk);
    check("R7 reset tx_valid", {30'b0, tx_valid}, 32'h0);
    check("R4 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // address map walk (R1, R2, R4, R7)
    for (int i = 0; i < 12; i++) begin
      rd(VEC[i][32:17]);
      check("R1 fault", {31'b0, s_fault}, {31'b0, VEC[i][16]});
      if (VEC[i][16]) begin
        check("R2 no mem_en", {31'b0, s_men}, 32'h0);
        check("R2 no rsp", {31'b0, s_rvalid}, 32'h0);
      end else begin
        check("R3 mem_en", {31'b0, s_men}, 32'h1);
        check("R4 rsp_valid", {31'b0, s_rvalid}, 32'h1);
        check("R4 R7 rdata", {16'b0, s_rdata}, {16'b0, VEC[i][15:0]});
      end
    end

    // R6: data-port write on channel 0
    wrt(16'h6000, 16'hABCD);
    check("R3 write addr", {16'b0, last_wa}, 32'h6000);
    check("R6 memory updated", {16'b0, last_wd}, 32'hABCD);
    check("R6 tx_valid", {30'b0, tx_valid}, 32'h1);
    check("R6 tx_byte", {24'b0, tx_byte[7:0]}, 32'hCD);
    rd(16'h6001);
    check("R6 ready cleared", {16'b0, s_rdata}, 32'h0);
    rd(16'h6003);
    check("R10 ch1 untouched", {16'b0, s_rdata}, 32'h1);

    // R8: transmitter accepts
    cyc(1'b0, 1'b0, 16'h0, 16'h0, 2'b00, 16'h0, 2'b01);
    check("R8 tx_valid drop", {30'b0, tx_valid}, 32'h0);
    rd(16'h6001);
    check("R8 ready set", {16'b0, s_rdata}, 32'h1);

    // R9 / R5 on channel 1
    cyc(1'b0, 1'b0, 16'h0, 16'h0, 2'b10, 16'h3C00, 2'b00);
    rd(16'h6003);
    check("R9 full set", {16'b0, s_rdata}, 32'h3);
    rd(16'h6001);
    check("R10 ch0 untouched", {16'b0, s_rdata}, 32'h1);
    rd(16'h6002);
    check("R5 rx byte", {16'b0, s_rdata}, 32'h3C);
    rd(16'h6003);
    check("R5 full cleared", {16'b0, s_rdata}, 32'h1);

    // R9: arrival coinciding with a data-port read on channel 0
    cyc(1'b0, 1'b0, 16'h0, 16'h0, 2'b01, 16'h0011, 2'b00);
    cyc(1'b1, 1'b0, 16'h6000, 16'h0, 2'b01, 16'h0022, 2'b00);
    check("R9 collide old byte", {16'b0, s_rdata}, 32'h11);
    rd(16'h6001);
    check("R9 collide full kept", {16'b0, s_rdata}, 32'h3);
    rd(16'h6000);
    check("R9 collide new byte", {16'b0, s_rdata}, 32'h22);

    // R11: status-word write goes to RAM only
    wrt(16'h6001, 16'hFFFE);
    check("R11 memory written", {16'b0, last_wd}, 32'hFFFE);
    check("R11 tx untouched", {30'b0, tx_valid}, 32'h0);
    rd(16'h6001);
    check("R11 status kept", {16'b0, s_rdata}, 32'h1);

    // R2: rejected writes
    wc = wr_cnt;
    wrt(16'h3000, 16'h1111);
    check("R2 write fault", {31'b0, s_fault}, 32'h1);
    wrt(16'h6004, 16'h2222);
    check("R2 no RAM write", wr_cnt, wc);
    check("R2 no tx", {30'b0, tx_valid}, 32'h0);

    // R3 plain write; R6 upper bits dropped on channel 1
    wrt(16'h1234, 16'hBEEF);
    check("R3 plain write", {last_wa, last_wd}, 32'h1234BEEF);
    wrt(16'h6002, 16'hFF80);
    check("R6 ch1 byte", {24'b0, tx_byte[15:8]}, 32'h80);
    check("R6 ch1 memory", {16'b0, last_wd}, 32'hFF80);
    check("R10 ch1 only", {30'b0, tx_valid}, 32'h2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule